// File: doc/BRIEF.md
# ADC Conversion Window Monitor

This block sits beside an ADC sequencer and inspects every conversion result as it is produced, with no software in the loop. Each result carries a channel number, a 12-bit sample, a valid strobe and a tag that marks it as a regular-group or an injected-group conversion. The monitor compares the sample against one low bound and one high bound. These bounds are shared by every channel it watches. A sample outside the bounds raises a sticky alarm.

Configuration inputs set the following:
- the two bounds;
- whether one chosen channel is watched or all channels are;
- the chosen channel;
- separate gates for regular and injected results;
- an interrupt enable.

When the alarm first sets, the monitor records the channel and sample of the result that caused it. Software can read that record back until it clears the alarm with a one-cycle clear pulse.

Top module: `adc_window_monitor`

## Requirements
- R1: A monitored result sets the flag one clock after it is presented when its sample is strictly below `lo_bound` or strictly above `hi_bound`. A sample equal to either bound is inside the window and does not set the flag.
- R2: When `lo_bound` is greater than `hi_bound`, every monitored result sets the flag.
- R3: With `single_mode` = 1, only results whose channel equals `sel_chan` are monitored. With `single_mode` = 0, results on any channel 0 to 17 are monitored.
- R4: A result with `res_inj` = 0 (regular group) is monitored only while `reg_en` = 1. A result with `res_inj` = 1 (injected group) is monitored only while `inj_en` = 1.
- R5: Once set, the flag stays set until a cycle with `flag_clr` = 1. An out-of-window result in the same cycle as `flag_clr` leaves the flag set.
- R6: `hit_chan` and `hit_data` take the channel and sample of the result that sets the flag from clear. Later out-of-window results do not change them while the flag remains set.
- R7: `irq` is high exactly when the flag is set and `irq_en` = 1. Further out-of-window results while the flag is set produce no new rising edge on `irq`.
- R8: After reset, `flag`, `irq`, `hit_chan` and `hit_data` are all zero.
- R9: Cycles with `res_valid` = 0 never set the flag, whatever the sample and channel inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Conversion result present this cycle |
| res_chan | input | 5 | Channel number of the result (0 to 17) |
| res_data | input | 12 | Converted sample |
| res_inj | input | 1 | 1 = injected group, 0 = regular group |
| lo_bound | input | 12 | Low bound of the window |
| hi_bound | input | 12 | High bound of the window |
| single_mode | input | 1 | 1 = watch `sel_chan` only, 0 = watch all channels |
| sel_chan | input | 5 | Channel watched in single mode |
| reg_en | input | 1 | Monitor regular-group results |
| inj_en | input | 1 | Monitor injected-group results |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | One-cycle clear of the sticky flag |
| flag | output | 1 | Sticky out-of-window flag |
| irq | output | 1 | Interrupt request |
| hit_chan | output | 5 | Channel of the result that set the flag |
| hit_data | output | 12 | Sample of the result that set the flag |

## Verification
The comparison is tried at both bounds, at one step beyond each bound, and with the bounds inverted. This separates strict from inclusive comparison and shows whether the inverted case is handled. Results are sent on the selected channel and on other channels, and in both groups under each gate setting. These patterns tell channel filtering apart from group filtering. A sequence of two hits, with a clear that coincides with a hit, distinguishes first-hit capture from last-hit capture. It also shows which of clear and set takes priority. Samples held on the inputs while the valid strobe is low confirm that only strobed results count.

// File: rtl/adc_window_monitor.sv
module adc_window_monitor #(
  parameter int DW = 12,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_valid,
  input  logic [CW-1:0] res_chan,
  input  logic [DW-1:0] res_data,
  input  logic          res_inj,
  input  logic [DW-1:0] lo_bound,
  input  logic [DW-1:0] hi_bound,
  input  logic          single_mode,
  input  logic [CW-1:0] sel_chan,
  input  logic          reg_en,
  input  logic          inj_en,
  input  logic          irq_en,
  input  logic          flag_clr,
  output logic          flag,
  output logic          irq,
  output logic [CW-1:0] hit_chan,
  output logic [DW-1:0] hit_data
);
  logic grp_ok, chan_ok, outside, hit, take;

  assign grp_ok  = res_inj ? inj_en : reg_en;
  assign chan_ok = !single_mode || (res_chan == sel_chan);
  assign outside = (res_data < lo_bound) || (res_data > hi_bound);
  assign hit     = res_valid && grp_ok && chan_ok && outside;
  assign take    = hit && (!flag || flag_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag     <= 1'b0;
      hit_chan <= '0;
      hit_data <= '0;
    end else begin
      flag <= hit || (flag && !flag_clr);
      if (take) begin
        hit_chan <= res_chan;
        hit_data <= res_data;
      end
    end
  end

  assign irq = flag && irq_en;
endmodule

module adc_window_monitor_chk #(
  parameter int DW = 12,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          res_valid,
  input logic [CW-1:0] res_chan,
  input logic [DW-1:0] res_data,
  input logic          res_inj,
  input logic [DW-1:0] lo_bound,
  input logic [DW-1:0] hi_bound,
  input logic          single_mode,
  input logic [CW-1:0] sel_chan,
  input logic          reg_en,
  input logic          inj_en,
  input logic          irq_en,
  input logic          flag_clr,
  input logic          flag,
  input logic          irq,
  input logic [CW-1:0] hit_chan,
  input logic [DW-1:0] hit_data
);
  assert_below_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !single_mode && !res_inj && reg_en && res_data < lo_bound) |=> flag);

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);

  assert_capture_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> ($stable(hit_chan) && $stable(hit_data)));

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && flag) |-> irq);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !res_valid) |=> !flag);
endmodule

bind adc_window_monitor adc_window_monitor_chk #(.DW(DW), .CW(CW)) u_chk (.*);

// File: tb/test_adc_window_monitor.sv
`timescale 1ns/1ps
module test_adc_window_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic [4:0]  res_chan = '0;
  logic [11:0] res_data = '0;
  logic        res_inj = 1'b0;
  logic [11:0] lo_bound = 12'd100;
  logic [11:0] hi_bound = 12'd200;
  logic        single_mode = 1'b0;
  logic [4:0]  sel_chan = '0;
  logic        reg_en = 1'b1;
  logic        inj_en = 1'b1;
  logic        irq_en = 1'b0;
  logic        flag_clr = 1'b0;
  logic        flag, irq;
  logic [4:0]  hit_chan;
  logic [11:0] hit_data;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  adc_window_monitor i_adc_window_monitor (.*);

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(int ch, int d, bit inj, bit clr = 1'b0);
    @(negedge clk);
    res_valid = 1'b1; res_chan = 5'(ch); res_data = 12'(d); res_inj = inj; flag_clr = clr;
    @(negedge clk);
    res_valid = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R8 flag", flag, 0);
    check("R8 irq", irq, 0);
    check("R8 hit_chan", hit_chan, 0);
    check("R8 hit_data", hit_data, 0);
  endtask

  task automatic t_window();
    lo_bound = 100; hi_bound = 200;
    send(1, 100, 0); check("R1 equal low", flag, 0);
    send(1, 200, 0); check("R1 equal high", flag, 0);
    send(4, 99, 0);  check("R1 below", flag, 1);
    check("R6 chan", hit_chan, 4); check("R6 data", hit_data, 99);
    clear(); check("R5 cleared", flag, 0);
    send(1, 201, 0); check("R1 above", flag, 1);
    clear();
  endtask

  task automatic t_invalid();
    @(negedge clk); res_valid = 0; res_data = 0; res_chan = 1;
    @(negedge clk); @(negedge clk);
    check("R9 no valid", flag, 0);
  endtask

  task automatic t_inverted();
    lo_bound = 300; hi_bound = 200;
    send(2, 250, 0); check("R2 inverted", flag, 1);
    clear();
    lo_bound = 100; hi_bound = 200;
  endtask

  task automatic t_channel();
    single_mode = 1; sel_chan = 7;
    send(3, 0, 0);  check("R3 other chan", flag, 0);
    send(7, 0, 0);  check("R3 sel chan", flag, 1);
    check("R3 cap chan", hit_chan, 7);
    clear();
    single_mode = 0;
    send(17, 4000, 0); check("R3 all chan 17", flag, 1);
    clear();
  endtask

  task automatic t_group();
    reg_en = 0; inj_en = 1;
    send(1, 0, 0); check("R4 regular gated", flag, 0);
    send(1, 0, 1); check("R4 injected on", flag, 1);
    clear();
    reg_en = 1; inj_en = 0;
    send(1, 0, 1); check("R4 injected gated", flag, 0);
    send(1, 0, 0); check("R4 regular on", flag, 1);
    clear();
    inj_en = 1;
  endtask

  task automatic t_sticky();
    send(2, 10, 0);
    send(5, 20, 0);
    check("R6 first chan", hit_chan, 2); check("R6 first data", hit_data, 10);
    repeat (3) @(negedge clk);
    check("R5 held", flag, 1);
    send(9, 30, 0, 1'b1);
    check("R5 clr with hit", flag, 1);
    check("R6 recapture chan", hit_chan, 9); check("R6 recapture data", hit_data, 30);
  endtask

  task automatic t_irq();
    irq_en = 0; #1;
    check("R7 masked", irq, 0);
    irq_en = 1; #1;
    check("R7 enabled", irq, 1);
    send(3, 5, 0);
    check("R7 stays high", irq, 1);
    clear();
    check("R7 low after clear", irq, 0);
    irq_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_window();
    t_invalid();
    t_inverted();
    t_channel();
    t_group();
    t_sticky();
    t_irq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule